// File: doc/BRIEF.md
# Batch Round-Robin Warp Issue Selector

This block sits in the fetch stage of a multi-warp SIMT core and names, every cycle, the one warp whose next instruction is fetched. It holds four warp masks: which warps are running, which are held by decode for a pending state change, which wait at a barrier, and which still belong to the current issue batch. The batch is drained lowest-numbered warp first. When no warp of the batch is still eligible, it is reloaded in that same cycle from the warps that are running and held by neither decode nor a barrier. The result is round-robin fairness without a rotating pointer.

Control arrives as single-cycle events: decode holds or frees a warp, the barrier unit sets or clears hold bits by mask, a spawn event rewrites the set of running warps from a count, and a warp leaves the running set when its thread mask reaches zero. Each event changes the masks at the next clock edge, so it affects the selection from the following cycle on. The selection output is a plain valid flag with a warp index and carries no back-pressure. A warp is considered fetched in every cycle in which it is shown.

Top module: `warp_batch_sched`

## Requirements
- R1: After reset only warp 0 is running, no warp is held, and the batch is empty, so warp 0 is issued in every cycle.
- R2: While the batch holds eligible warps, the lowest-numbered one is issued and leaves the batch. Within a batch, successive issues therefore have strictly rising warp numbers.
- R3: When the batch holds no eligible warp, it is reloaded from the warps that are running and not held, and the lowest of them is issued in the same cycle. With warps 0 and 1 running, the order is 0, 1, 0, 1.
- R4: When no warp is running and unheld, `issue_valid` is 0.
- R5: A decode hold on warp `stall_wid` takes effect in the next cycle. The warp is then skipped even if it is still in the current batch, and it is left out of reloads.
- R6: A decode release on warp `unstall_wid` frees it for the next reload. If a hold and a release for the same warp arrive in the same cycle, the hold wins.
- R7: Bits set in `bar_hold_set` hold those warps from the next cycle, and bits set in `bar_hold_clr` free them. If both masks set the same bit in one cycle, the hold wins.
- R8: A spawn event with count N makes warps 0..N-1 running and all others not running. A count of 0 leaves no warp running, and a count above the warp number runs every warp. Newly running warps are first issued at the next reload, not in the batch already under way.
- R9: A zero-thread-mask event removes warp `retire_wid` from the running set at the next edge. In the same cycle as a spawn, the removal wins.
- R10: Whenever `issue_valid` is 0, `issue_wid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_req | input | 1 | Decode holds warp `stall_wid` |
| stall_wid | input | WID_W | Warp to hold |
| unstall_req | input | 1 | Thread-mask update frees warp `unstall_wid` |
| unstall_wid | input | WID_W | Warp to free |
| bar_hold_set | input | NUM_WARPS | Warps entering barrier hold |
| bar_hold_clr | input | NUM_WARPS | Warps released from barrier hold |
| spawn_valid | input | 1 | Spawn event |
| spawn_count | input | CNT_W | Number of running warps after the spawn |
| retire_valid | input | 1 | A warp's thread mask became zero |
| retire_wid | input | WID_W | The warp that became empty |
| issue_valid | output | 1 | A warp is selected this cycle |
| issue_wid | output | WID_W | Selected warp index |

## Verification
Two pairs of events can land in the same cycle and must be resolved by a fixed rule. A spawn can coincide with a zero-thread-mask event for a warp the spawn would run, and a hold can coincide with a release for the same warp, both from decode and from the barrier masks. The bench drives each pair in one cycle, at a point where the batch is empty. It then checks that the next issue sequence leaves the affected warp out, which is what the winning removal or hold predicts. A separate sequence frees the warp again, to show that the earlier result came from the rule and not from a stuck bit.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE   = 2'd0,
    SRC_BATCH  = 2'd1,
    SRC_REFILL = 2'd2
  } pick_src_e;
endpackage

// File: rtl/wbs_mask_bank.sv
module wbs_mask_bank #(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall_req,
  input  logic [WID_W-1:0]     stall_wid,
  input  logic                 unstall_req,
  input  logic [WID_W-1:0]     unstall_wid,
  input  logic [NUM_WARPS-1:0] bar_hold_set,
  input  logic [NUM_WARPS-1:0] bar_hold_clr,
  input  logic                 spawn_valid,
  input  logic [CNT_W-1:0]     spawn_count,
  input  logic                 retire_valid,
  input  logic [WID_W-1:0]     retire_wid,
  output logic [NUM_WARPS-1:0] eligible
);
  localparam logic [NUM_WARPS-1:0] ONE = NUM_WARPS'(1);

  logic [NUM_WARPS-1:0] active_q, stalled_q, bar_q;
  logic [NUM_WARPS-1:0] stall_1h, unstall_1h, retire_1h, spawn_mask;

  assign stall_1h   = stall_req    ? (ONE << stall_wid)   : '0;
  assign unstall_1h = unstall_req  ? (ONE << unstall_wid) : '0;
  assign retire_1h  = retire_valid ? (ONE << retire_wid)  : '0;

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_spawn
    assign spawn_mask[g] = (spawn_count > CNT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= ONE;
      stalled_q <= '0;
      bar_q     <= '0;
    end else begin
      active_q  <= (spawn_valid ? spawn_mask : active_q) & ~retire_1h;
      stalled_q <= (stalled_q & ~unstall_1h) | stall_1h;
      bar_q     <= (bar_q & ~bar_hold_clr) | bar_hold_set;
    end
  end

  assign eligible = active_q & ~stalled_q & ~bar_q;

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |=> stalled_q[$past(stall_wid)]);

  assert_retire_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> !active_q[$past(retire_wid)]);

  assert_bar_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bar_hold_set) |=> ((bar_q & $past(bar_hold_set)) == $past(bar_hold_set)));
endmodule

// File: rtl/wbs_lowest_pick.sv
module wbs_lowest_pick #(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = 2
) (
  input  logic [NUM_WARPS-1:0] req,
  output logic [NUM_WARPS-1:0] grant,
  output logic [WID_W-1:0]     idx,
  output logic                 any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NUM_WARPS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = WID_W'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/warp_batch_sched.sv
module warp_batch_sched #(
  parameter int NUM_WARPS = 4,
  parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  parameter int CNT_W     = $clog2(NUM_WARPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall_req,
  input  logic [WID_W-1:0]     stall_wid,
  input  logic                 unstall_req,
  input  logic [WID_W-1:0]     unstall_wid,
  input  logic [NUM_WARPS-1:0] bar_hold_set,
  input  logic [NUM_WARPS-1:0] bar_hold_clr,
  input  logic                 spawn_valid,
  input  logic [CNT_W-1:0]     spawn_count,
  input  logic                 retire_valid,
  input  logic [WID_W-1:0]     retire_wid,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_wid
);
  import wbs_pkg::*;

  logic [NUM_WARPS-1:0] eligible, vis_q, batch_req, pick_req, grant;
  logic                 use_batch, any;
  logic [WID_W-1:0]     idx;
  pick_src_e            src;

  wbs_mask_bank #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .CNT_W(CNT_W)) i_masks (
    .clk(clk), .rst_n(rst_n),
    .stall_req(stall_req), .stall_wid(stall_wid),
    .unstall_req(unstall_req), .unstall_wid(unstall_wid),
    .bar_hold_set(bar_hold_set), .bar_hold_clr(bar_hold_clr),
    .spawn_valid(spawn_valid), .spawn_count(spawn_count),
    .retire_valid(retire_valid), .retire_wid(retire_wid),
    .eligible(eligible)
  );

  // Batch members that lost eligibility are dropped, not waited for.
  assign batch_req = vis_q & eligible;
  assign use_batch = |batch_req;
  assign pick_req  = use_batch ? batch_req : eligible;

  wbs_lowest_pick #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) i_pick (
    .req(pick_req), .grant(grant), .idx(idx), .any(any)
  );

  always_comb begin
    if (!any)          src = SRC_IDLE;
    else if (use_batch) src = SRC_BATCH;
    else               src = SRC_REFILL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vis_q <= '0;
    else        vis_q <= pick_req & ~grant;
  end

  assign issue_valid = any;
  assign issue_wid   = idx;

  assert_issue_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> eligible[issue_wid]);

  assert_idle_only_if_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (eligible == '0));

  assert_batch_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_BATCH) |-> (issue_wid > $past(issue_wid)));

  assert_spawn_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spawn_valid && spawn_count == '0 && !retire_valid) |=> !issue_valid);

  assert_idle_wid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (issue_wid == '0));
endmodule

// File: tb/test_warp_batch_sched.sv
`timescale 1ns/1ps
module test_warp_batch_sched;
  localparam int W  = 4;
  localparam int WW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall_req, unstall_req, spawn_valid, retire_valid;
  logic [WW-1:0] stall_wid, unstall_wid, retire_wid;
  logic [W-1:0]  bar_hold_set, bar_hold_clr;
  logic [CW-1:0] spawn_count;
  logic          issue_valid;
  logic [WW-1:0] issue_wid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  warp_batch_sched #(.NUM_WARPS(W)) i_warp_batch_sched (
    .clk(clk), .rst_n(rst_n),
    .stall_req(stall_req), .stall_wid(stall_wid),
    .unstall_req(unstall_req), .unstall_wid(unstall_wid),
    .bar_hold_set(bar_hold_set), .bar_hold_clr(bar_hold_clr),
    .spawn_valid(spawn_valid), .spawn_count(spawn_count),
    .retire_valid(retire_valid), .retire_wid(retire_wid),
    .issue_valid(issue_valid), .issue_wid(issue_wid)
  );

  task automatic clear_pulses();
    stall_req = 0; stall_wid = '0; unstall_req = 0; unstall_wid = '0;
    bar_hold_set = '0; bar_hold_clr = '0;
    spawn_valid = 0; spawn_count = '0; retire_valid = 0; retire_wid = '0;
  endtask

  // Inputs set just after a negedge act at the next posedge.
  task automatic commit();
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic check_issue(input bit ev, input int ew, input string req);
    checks++;
    if (issue_valid !== ev || int'(issue_wid) != (ev ? ew : 0)) begin
      fails++;
      $display("FAIL %s: got valid=%0b wid=%0d, expected valid=%0b wid=%0d",
               req, issue_valid, issue_wid, ev, ev ? ew : 0);
    end
  endtask

  task automatic expect_run(input int n, input int seq[8], input string req);
    for (int k = 0; k < n; k++) begin
      check_issue(1'b1, seq[k], req);
      @(negedge clk);
    end
  endtask

  task automatic wait_for(input int w);
    int guard = 0;
    while (!(issue_valid && int'(issue_wid) == w) && guard < 20) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_reset();
    expect_run(3, '{0,0,0,0,0,0,0,0}, "R1 reset only warp0");
  endtask

  task automatic t_spawn_two();
    spawn_valid = 1; spawn_count = 3'd2; commit();
    expect_run(4, '{0,1,0,1,0,0,0,0}, "R3 two-warp order");
  endtask

  task automatic t_decode_hold();
    wait_for(0);
    stall_req = 1; stall_wid = 2'd0; commit();
    expect_run(3, '{1,1,1,0,0,0,0,0}, "R5 held warp0 excluded");
    unstall_req = 1; unstall_wid = 2'd0; commit();
    expect_run(2, '{0,1,0,0,0,0,0,0}, "R6 warp0 freed");
  endtask

  task automatic t_spawn_mid_batch();
    wait_for(0);
    spawn_valid = 1; spawn_count = 3'd4; commit();
    expect_run(5, '{1,0,1,2,3,0,0,0}, "R8 new warps wait for reload");
  endtask

  task automatic t_hold_in_batch();
    wait_for(0);
    stall_req = 1; stall_wid = 2'd2; commit();
    expect_run(5, '{1,3,0,1,3,0,0,0}, "R5 skip held batch member");
    wait_for(0);
    unstall_req = 1; unstall_wid = 2'd2; commit();
    expect_run(6, '{1,3,0,1,2,3,0,0}, "R2 ascending batch after free");
  endtask

  task automatic t_barrier();
    wait_for(3);
    bar_hold_set = 4'b0110; commit();
    expect_run(4, '{0,3,0,3,0,0,0,0}, "R7 barrier hold");
    wait_for(0);
    bar_hold_clr = 4'b0110; commit();
    expect_run(5, '{3,0,1,2,3,0,0,0}, "R7 barrier release");
    wait_for(3);
    bar_hold_set = 4'b0010; bar_hold_clr = 4'b0010; commit();
    expect_run(3, '{0,2,3,0,0,0,0,0}, "R7 set wins over clear");
    wait_for(0);
    bar_hold_clr = 4'b0010; commit();
    expect_run(4, '{2,3,0,1,0,0,0,0}, "R7 clear alone frees");
  endtask

  task automatic t_retire();
    wait_for(3);
    retire_valid = 1; retire_wid = 2'd2; commit();
    expect_run(4, '{0,1,3,0,0,0,0,0}, "R9 empty warp leaves");
  endtask

  task automatic t_spawn_retire_collide();
    wait_for(3);
    spawn_valid = 1; spawn_count = 3'd4; retire_valid = 1; retire_wid = 2'd3; commit();
    expect_run(4, '{0,1,2,0,0,0,0,0}, "R9 retire wins over spawn");
  endtask

  task automatic t_hold_release_collide();
    wait_for(2);
    stall_req = 1; stall_wid = 2'd1; unstall_req = 1; unstall_wid = 2'd1; commit();
    expect_run(3, '{0,2,0,0,0,0,0,0}, "R6 hold wins over release");
    wait_for(2);
    unstall_req = 1; unstall_wid = 2'd1; commit();
    expect_run(3, '{0,1,2,0,0,0,0,0}, "R6 release alone frees");
  endtask

  task automatic t_idle_and_clamp();
    spawn_valid = 1; spawn_count = 3'd0; commit();
    check_issue(1'b0, 0, "R4 no running warp");
    @(negedge clk);
    check_issue(1'b0, 0, "R10 idle index zero");
    spawn_valid = 1; spawn_count = 3'd1; commit();
    expect_run(2, '{0,0,0,0,0,0,0,0}, "R8 count one");
    stall_req = 1; stall_wid = 2'd0; commit();
    check_issue(1'b0, 0, "R4 only warp held");
    unstall_req = 1; unstall_wid = 2'd0; spawn_valid = 1; spawn_count = 3'd7; commit();
    expect_run(5, '{0,1,2,3,0,0,0,0}, "R8 count above warp number");
  endtask

  initial begin
    clear_pulses();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_spawn_two();
    t_decode_hold();
    t_spawn_mid_batch();
    t_hold_in_batch();
    t_barrier();
    t_retire();
    t_spawn_retire_collide();
    t_hold_release_collide();
    t_idle_and_clamp();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): got no completion, expected end before %0d cycles", 20000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule